// File: doc/BRIEF.md
# Segment-Control Address Translator

This block classifies a 32-bit virtual address for a processor whose address space is split into fixed segments. Each segment's behaviour is not hard-wired. It is set by a 16-bit control field held in one half of three 32-bit control registers. The block finds the segment the address falls in and picks that segment's control field. It then decodes the field's access mode against the current privilege level and reports one of three outcomes: address error, TLB-mapped, or unmapped.

For an unmapped access the block also forms a 36-bit physical address from the field's physical-base bits and the address offset, and grants read, write and execute permission. A TLB-mapped outcome is passed on to a TLB stage that sits outside this block.

Timing is set by a two-state controller. ST_IDLE means no result is presented. ST_SHOW means a result is presented. The transition GO_SHOW is taken on any cycle with `in_valid` high, and GO_IDLE is taken on any cycle with `in_valid` low. Results are registered, so they appear one cycle after the request.

Top module: `segxl_top`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. After reset, `out_valid`, `out_kind`, `out_paddr` and `out_perm` are all zero. `out_kind` uses 0 for unmapped, 1 for TLB-mapped and 2 for address error, and never takes the value 3.
- R2: Addresses below 0x80000000 form one 1 GB-offset segment with offset mask 0x3FFFFFFF. Addresses below 0x40000000 use bits 31:16 of `in_segctl2`. Addresses from 0x40000000 up to 0x7FFFFFFF use bits 15:0 of `in_segctl2`.
- R3: Upper addresses are decoded by bits 31:29, with offset mask 0x1FFFFFFF. The value 100 selects `in_segctl1`[31:16], 101 selects `in_segctl1`[15:0], 110 selects `in_segctl0`[31:16] and 111 selects `in_segctl0`[15:0].
- R4: Privilege is encoded as 0 kernel, 1 supervisor, 2 user and 3 error level. In a control field, bits 6:4 hold the access mode. In kernel mode, access modes 1, 2 and 3 are TLB-mapped, modes 0, 4, 5 and 7 are unmapped, and no mode other than 6 gives an address error.
- R5: In supervisor mode, access modes 0 and 1 give an address error. Modes 2, 3 and 4 are TLB-mapped, and modes 5 and 7 are unmapped.
- R6: In user mode, access modes 0, 1, 2 and 5 give an address error. Modes 3 and 4 are TLB-mapped, and mode 7 is unmapped.
- R7: Error level follows the kernel rules. The exception is that when bit 3 of the field (the unmapped-override bit) is set, the result is unmapped.
- R8: Access mode 6 gives an address error at every privilege level, including error level with the override bit set. An address error takes priority over both other outcomes.
- R9: For an unmapped result, `out_paddr` is built in two parts. The field's bits 15:9 are placed at physical bits 35:29, and the bits covered by the segment's offset mask are cleared. The virtual address ANDed with the offset mask is then ORed in.
- R10: `out_perm` (bit 0 read, bit 1 write, bit 2 execute) is 3'b111 for an unmapped result. For the other two results, `out_perm` is 0 and `out_paddr` is 0.
- R11: Bits 8:7 and 2:0 of a control field have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_vaddr | input | 32 | Virtual address |
| in_priv | input | 2 | Privilege level (0 kernel, 1 supervisor, 2 user, 3 error level) |
| in_segctl0 | input | 32 | Control fields for 0xC0000000 (high half) and 0xE0000000 (low half) |
| in_segctl1 | input | 32 | Control fields for 0x80000000 (high half) and 0xA0000000 (low half) |
| in_segctl2 | input | 32 | Control fields for the lower 1 GB (high half) and the upper 1 GB (low half) of the region below 0x80000000 |
| out_valid | output | 1 | Result presented |
| out_kind | output | 2 | 0 unmapped, 1 TLB-mapped, 2 address error |
| out_paddr | output | 36 | Physical address for unmapped results |
| out_perm | output | 3 | Read/write/execute permission bits |

## Verification
The properties assume that the address, privilege and control-register inputs hold known values in every cycle where `in_valid` is high. They also assume that these inputs are sampled only in that cycle, because the block keeps no copy of a request once it has been accepted. The stimulus drives every input to a defined value from reset onward and changes it only at falling clock edges. The unselected control halves are filled with the reserved access mode, so a wrong segment choice shows up as an address error.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
    localparam int VA_W = 32;
    localparam int CTL_W = 16;

    typedef enum logic [1:0] {
        PRV_KERN = 2'd0,
        PRV_SUPV = 2'd1,
        PRV_USER = 2'd2,
        PRV_ERRL = 2'd3
    } prv_t;

    typedef enum logic [1:0] {
        XL_UNMAPPED = 2'd0,
        XL_MAPPED   = 2'd1,
        XL_ADDRERR  = 2'd2
    } xl_kind_t;

    typedef struct packed {
        logic [6:0] pa;
        logic [1:0] rsv_hi;
        logic [2:0] am;
        logic       eu;
        logic [2:0] rsv_lo;
    } segctl_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } st_t;
endpackage

// File: rtl/segxl_select.sv
module segxl_select
    import segxl_pkg::*;
(
    input  logic [VA_W-1:0]    vaddr,
    input  logic [2*CTL_W-1:0] ctl0,
    input  logic [2*CTL_W-1:0] ctl1,
    input  logic [2*CTL_W-1:0] ctl2,
    output segctl_t            field,
    output logic [VA_W-1:0]    offmask
);
    localparam logic [VA_W-1:0] LOW_MASK  = 32'h3FFF_FFFF;
    localparam logic [VA_W-1:0] HIGH_MASK = 32'h1FFF_FFFF;

    always_comb begin
        unique case (vaddr[VA_W-1 -: 3])
            3'b000, 3'b001: begin
                field   = segctl_t'(ctl2[2*CTL_W-1:CTL_W]);
                offmask = LOW_MASK;
            end
            3'b010, 3'b011: begin
                field   = segctl_t'(ctl2[CTL_W-1:0]);
                offmask = LOW_MASK;
            end
            3'b100: begin
                field   = segctl_t'(ctl1[2*CTL_W-1:CTL_W]);
                offmask = HIGH_MASK;
            end
            3'b101: begin
                field   = segctl_t'(ctl1[CTL_W-1:0]);
                offmask = HIGH_MASK;
            end
            3'b110: begin
                field   = segctl_t'(ctl0[2*CTL_W-1:CTL_W]);
                offmask = HIGH_MASK;
            end
            default: begin
                field   = segctl_t'(ctl0[CTL_W-1:0]);
                offmask = HIGH_MASK;
            end
        endcase
    end
endmodule

// File: rtl/segxl_policy.sv
module segxl_policy
    import segxl_pkg::*;
(
    input  prv_t       priv,
    input  logic [2:0] am,
    input  logic       eu,
    output xl_kind_t   kind
);
    logic err;
    logic map;

    always_comb begin
        err = 1'b0;
        map = 1'b0;
        unique case (priv)
            PRV_KERN, PRV_ERRL: begin
                map = (am == 3'd1) || (am == 3'd2) || (am == 3'd3);
            end
            PRV_SUPV: begin
                err = (am == 3'd0) || (am == 3'd1);
                map = (am == 3'd2) || (am == 3'd3) || (am == 3'd4);
            end
            default: begin
                err = (am == 3'd0) || (am == 3'd1) || (am == 3'd2) || (am == 3'd5);
                map = (am == 3'd3) || (am == 3'd4);
            end
        endcase
        if ((priv == PRV_ERRL) && eu) map = 1'b0;
        if (am == 3'd6) err = 1'b1;
        if (err)      kind = XL_ADDRERR;
        else if (map) kind = XL_MAPPED;
        else          kind = XL_UNMAPPED;
    end
endmodule

// File: rtl/segxl_phys.sv
module segxl_phys
    import segxl_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic [6:0]      pa_field,
    input  logic [VA_W-1:0] vaddr,
    input  logic [VA_W-1:0] offmask,
    output logic [PA_W-1:0] paddr
);
    localparam int BASE_LSB = PA_W - 7;
    localparam int EXT_W    = PA_W - VA_W;

    logic [PA_W-1:0] base;
    logic [PA_W-1:0] mask_ext;

    assign base     = {pa_field, {BASE_LSB{1'b0}}};
    assign mask_ext = {{EXT_W{1'b0}}, offmask};
    assign paddr    = (base & ~mask_ext) | {{EXT_W{1'b0}}, vaddr & offmask};
endmodule

// File: rtl/segxl_top.sv
module segxl_top
    import segxl_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      in_vaddr,
    input  logic [1:0]       in_priv,
    input  logic [31:0]      in_segctl0,
    input  logic [31:0]      in_segctl1,
    input  logic [31:0]      in_segctl2,
    output logic             out_valid,
    output logic [1:0]       out_kind,
    output logic [PA_W-1:0]  out_paddr,
    output logic [2:0]       out_perm
);
    localparam logic [2:0] PERM_RWX = 3'b111;

    segctl_t         field;
    logic [VA_W-1:0] offmask;
    xl_kind_t        kind_c;
    logic [PA_W-1:0] paddr_c;
    logic            unused_rsv;
    st_t             state_q;
    st_t             state_d;

    assign unused_rsv = ^{field.rsv_hi, field.rsv_lo};

    segxl_select u_select (
        .vaddr   (in_vaddr),
        .ctl0    (in_segctl0),
        .ctl1    (in_segctl1),
        .ctl2    (in_segctl2),
        .field   (field),
        .offmask (offmask)
    );

    segxl_policy u_policy (
        .priv (prv_t'(in_priv)),
        .am   (field.am),
        .eu   (field.eu),
        .kind (kind_c)
    );

    segxl_phys #(.PA_W(PA_W)) u_phys (
        .pa_field (field.pa),
        .vaddr    (in_vaddr),
        .offmask  (offmask),
        .paddr    (paddr_c)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_kind  <= XL_UNMAPPED;
            out_paddr <= '0;
            out_perm  <= '0;
        end else if (in_valid) begin
            out_kind <= kind_c;
            if (kind_c == XL_UNMAPPED) begin
                out_paddr <= paddr_c;
                out_perm  <= PERM_RWX;
            end else begin
                out_paddr <= '0;
                out_perm  <= '0;
            end
        end
    end

    assign out_valid = (state_q == ST_SHOW);
endmodule

// File: rtl/segxl_checker.sv
module segxl_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_vaddr,
    input logic [1:0]  in_priv,
    input logic [31:0] in_segctl0,
    input logic [31:0] in_segctl1,
    input logic        out_valid,
    input logic [1:0]  out_kind,
    input logic [35:0] out_paddr,
    input logic [2:0]  out_perm
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_kind != 2'd3)); // R1
    AST_KERN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_priv == 2'd0 && in_vaddr[31:29] == 3'b100 && in_segctl1[22:20] != 3'd6)
        |=> (out_kind != 2'd2)); // R4
    AST_AM7_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_vaddr[31:29] == 3'b111 && in_segctl0[6:4] == 3'd7)
        |=> (out_kind == 2'd0)); // R6
    AST_RSVD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_vaddr[31:29] == 3'b110 && in_segctl0[22:20] == 3'd6)
        |=> (out_kind == 2'd2)); // R8
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_vaddr[31]) |=> (out_kind != 2'd0 || out_paddr[28:0] == $past(in_vaddr[28:0]))); // R9
    AST_PERM_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 2'd0) |-> (out_perm == 3'b111)); // R10
    AST_PERM_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind != 2'd0) |-> (out_perm == 3'b000 && out_paddr == 36'd0)); // R10
endmodule

bind segxl_top segxl_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_vaddr   (in_vaddr),
    .in_priv    (in_priv),
    .in_segctl0 (in_segctl0),
    .in_segctl1 (in_segctl1),
    .out_valid  (out_valid),
    .out_kind   (out_kind),
    .out_paddr  (out_paddr),
    .out_perm   (out_perm)
);

// File: tb/tb_segxl_top.sv
`timescale 1ns/1ps
module tb_segxl_top;
    typedef struct packed {
        logic [1:0]  priv;
        logic [31:0] va;
        logic [15:0] ctl;
        logic [1:0]  kind;
        logic [35:0] pa;
    } vec_t;

    localparam logic [15:0] FILL = 16'h0060;
    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h8000_1234, 16'h0A00, 2'd0, 36'h0_A000_1234}, // R3 R4 R9 R10
        '{2'd0, 32'hA000_0010, 16'h0010, 2'd1, 36'h0},           // R3 R4
        '{2'd0, 32'hC0FF_0000, 16'hFE40, 2'd0, 36'hF_E0FF_0000}, // R3 R4 R9
        '{2'd0, 32'hE000_0004, 16'h0060, 2'd2, 36'h0},           // R8
        '{2'd1, 32'hE123_4567, 16'h0000, 2'd2, 36'h0},           // R5
        '{2'd1, 32'hC000_0000, 16'h0020, 2'd1, 36'h0},           // R5
        '{2'd1, 32'h8765_4321, 16'h0250, 2'd0, 36'h0_2765_4321}, // R5 R9
        '{2'd2, 32'h1234_5678, 16'h0030, 2'd1, 36'h0},           // R2 R6
        '{2'd2, 32'h4000_0100, 16'h0050, 2'd2, 36'h0},           // R2 R6
        '{2'd2, 32'h7FFF_FFF0, 16'hFE70, 2'd0, 36'hF_FFFF_FFF0}, // R2 R6 R9
        '{2'd2, 32'h0000_0040, 16'h0040, 2'd1, 36'h0},           // R2 R6
        '{2'd3, 32'hA000_0008, 16'h0018, 2'd0, 36'h0_0000_0008}, // R7
        '{2'd3, 32'hA000_0008, 16'h0010, 2'd1, 36'h0},           // R7
        '{2'd3, 32'h8000_0000, 16'h0068, 2'd2, 36'h0},           // R8
        '{2'd1, 32'hE000_0000, 16'h0040, 2'd1, 36'h0},           // R5
        '{2'd2, 32'hC000_0000, 16'h0020, 2'd2, 36'h0},           // R6
        '{2'd0, 32'h2000_0000, 16'h0650, 2'd0, 36'h0_6000_0000}  // R2 R9
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_vaddr = '0;
    logic [1:0]  in_priv = '0;
    logic [31:0] in_segctl0 = {FILL, FILL};
    logic [31:0] in_segctl1 = {FILL, FILL};
    logic [31:0] in_segctl2 = {FILL, FILL};
    logic        out_valid;
    logic [1:0]  out_kind;
    logic [35:0] out_paddr;
    logic [2:0]  out_perm;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    segxl_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vaddr(in_vaddr),
        .in_priv(in_priv), .in_segctl0(in_segctl0), .in_segctl1(in_segctl1),
        .in_segctl2(in_segctl2), .out_valid(out_valid), .out_kind(out_kind),
        .out_paddr(out_paddr), .out_perm(out_perm)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] p);
        case (p)
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic place(input logic [31:0] va, input logic [15:0] ctl);
        in_segctl0 = {FILL, FILL};
        in_segctl1 = {FILL, FILL};
        in_segctl2 = {FILL, FILL};
        if (!va[31]) begin
            if (va[30]) in_segctl2[15:0] = ctl;
            else        in_segctl2[31:16] = ctl;
        end else begin
            case (va[30:29])
                2'd0: in_segctl1[31:16] = ctl;
                2'd1: in_segctl1[15:0] = ctl;
                2'd2: in_segctl0[31:16] = ctl;
                default: in_segctl0[15:0] = ctl;
            endcase
        end
    endtask

    task automatic apply(input vec_t v, input string req);
        @(negedge clk);
        in_priv  = v.priv;
        in_vaddr = v.va;
        place(v.va, v.ctl);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 valid", 64'(out_valid), 64'd1);
        chk({req, " kind"}, 64'(out_kind), 64'(v.kind));
        chk("R9 paddr", 64'(out_paddr), 64'(v.pa));
        chk("R10 perm", 64'(out_perm), (v.kind == 2'd0) ? 64'd7 : 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset kind", 64'(out_kind), 64'd0);
        chk("R1 reset paddr", 64'(out_paddr), 64'd0);
        chk("R1 reset perm", 64'(out_perm), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", 64'(out_valid), 64'd0);

        for (int i = 0; i < NV; i++) apply(VECS[i], req_of(VECS[i].priv));

        // R1: output drops once no request follows
        @(negedge clk);
        chk("R1 drop", 64'(out_valid), 64'd0);

        // R11: ignored bits 8:7 and 2:0 set, same result as first vector
        apply('{2'd0, 32'h8000_1234, 16'h0B87, 2'd0, 36'h0_A000_1234}, "R11");
        // R11: ignored bits on a mapped field keep it mapped
        apply('{2'd2, 32'h4000_0000, 16'h01BF, 2'd1, 36'h0}, "R11");

        // R1: back-to-back requests keep valid high
        @(negedge clk);
        in_priv = 2'd0; in_vaddr = 32'hA000_0000; place(32'hA000_0000, 16'h0010);
        in_valid = 1'b1;
        @(negedge clk);
        in_vaddr = 32'hE000_0000; place(32'hE000_0000, 16'h0070);
        chk("R1 first", 64'(out_kind), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 second valid", 64'(out_valid), 64'd1);
        chk("R4 second kind", 64'(out_kind), 64'd0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule